// File: doc/BRIEF.md
# Three-Channel Byte-Port Interval Timer

This block holds three 16-bit down counters behind one byte-wide host port. A two-bit address picks one of four locations. Three of them are the counter channels and the fourth accepts command bytes. A command byte names a channel and chooses how that channel's 16-bit value crosses the 8-bit bus. The choices are the low byte only, the high byte only, a low/high pair, or a snapshot (latch) request. Each channel keeps its own byte pointers, so paired transfers on one channel never swap halves and never disturb another channel.

Every channel runs as a periodic rate generator. Its output idles high and drops for one counted tick at the end of every period. It counts the rising edges of its own clock pin while its gate pin is high. The channel clock and gate pins are sampled by the system clock, so all state lives in one clock domain. A static select input replaces the clock of channel 1 with the output of channel 0. This chains the two channels into one 32-bit timer.

Top module: `pit_timer`

## Requirements
- R1: After reset all three channel outputs are high, `rdata` is 0, and no channel counts until a full reload value has been written to it.
- R2: Address 0, 1 and 2 select channel 0, 1 and 2, and address 3 is the command location. `rdata` is registered and updates in the cycle after `rd_en`. A read of address 3 returns 0.
- R3: In a command byte, bits [7:6] select the channel (00, 01, 10), bits [5:4] select the access mode, and bits [3:0] (mode and BCD flag) are accepted but ignored. Every channel always counts in binary as a rate generator.
- R4: A command byte with access mode other than 00 stores that mode in the channel, resets its read and write byte pointers to the low byte, drops any held snapshot, stops counting and forces the output high from the next cycle on.
- R5: Access mode 01 moves only the low byte: a write loads {8'h00, data} and a read returns bits [7:0]. Access mode 10 moves only the high byte: a write loads {data, 8'h00} and a read returns bits [15:8].
- R6: In access mode 11 the first write stores the low byte and the second write stores the high byte and completes the load. Counting starts only once the load is complete.
- R7: In access mode 11 reads alternate low byte then high byte, with a read pointer kept apart from the write pointer.
- R8: Access mode 00 (latch) copies the current count into a hold register. Reads return the held value until every byte of the channel's access mode has been read, and then follow the live count again. A second latch while a value is held is ignored.
- R9: After a reload value N (2 to 65535) is loaded, the output falls on the (N-1)th counted tick and rises again on the Nth, when N is reloaded. The output then repeats with a period of N ticks.
- R10: A count tick is a rising edge of the channel clock pin seen by `clk`. While the gate is low the count holds.
- R11: With `chain_01` high, channel 1 counts the rising edges of channel 0's output instead of its own clock pin.
- R12: A command byte whose select field is 11 changes no channel state, including byte pointers, access modes and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Register select (0 to 2 channels, 3 command) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| ch_clk | input | 3 | Channel count clocks, one bit per channel |
| ch_gate | input | 3 | Channel gates, high enables counting |
| chain_01 | input | 1 | Clock channel 1 from channel 0's output |
| ch_out | output | 3 | Channel outputs |

## Verification
The hardest case to reach from the ports is a command or a second byte that arrives while a channel is partway through a sequence. Examples are a half-written paired load, a snapshot that is still held while counting goes on, or an output already low at the end of a period. The stimulus reaches these states by counting channel clock pulses one at a time from a known reload value. It then issues the command at an exactly chosen tick and reads the effect back through a latch and a paired read or through the output pin. The cascade case drives only channel 0's clock and then watches channel 1's output fall after the computed number of channel 0 periods.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NUM_CH = 3;
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] SEL_READBACK = 2'b11;

  typedef enum logic [1:0] {
    RW_LATCH = 2'b00,
    RW_LO    = 2'b01,
    RW_HI    = 2'b10,
    RW_PAIR  = 2'b11
  } rw_mode_e;
endpackage

// File: rtl/pit_edge.sv
module pit_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cw_hit,
  input  rw_mode_e      cw_rw,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          gate,
  output logic [DW-1:0] rd_byte,
  output logic          out
);
  localparam int CW = 2 * DW;

  rw_mode_e        mode_q;
  logic [CW-1:0]   reload_q, count_q, hold_q;
  logic [DW-1:0]   stage_q;
  logic            wptr_q, rptr_q, held_q, armed_q, out_q;
  logic [CW-1:0]   src, new_val;
  logic            load_now;

  always_comb begin
    src = held_q ? hold_q : count_q;
    case (mode_q)
      RW_HI:   rd_byte = src[CW-1:DW];
      RW_PAIR: rd_byte = rptr_q ? src[CW-1:DW] : src[DW-1:0];
      default: rd_byte = src[DW-1:0];
    endcase
  end

  always_comb begin
    load_now = 1'b0;
    new_val  = '0;
    case (mode_q)
      RW_LO:   begin load_now = 1'b1; new_val = {{DW{1'b0}}, wdata}; end
      RW_HI:   begin load_now = 1'b1; new_val = {wdata, {DW{1'b0}}}; end
      RW_PAIR: begin load_now = wptr_q; new_val = {wdata, stage_q}; end
      default: begin load_now = 1'b0; new_val = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= RW_PAIR;
      reload_q <= '0;
      count_q  <= '0;
      hold_q   <= '0;
      stage_q  <= '0;
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      held_q   <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= 1'b1;
    end else begin
      if (rd_hit) begin
        if (mode_q == RW_PAIR) begin
          rptr_q <= ~rptr_q;
          if (rptr_q) held_q <= 1'b0;
        end else begin
          held_q <= 1'b0;
        end
      end
      if (cw_hit) begin
        if (cw_rw == RW_LATCH) begin
          if (!held_q) begin
            held_q <= 1'b1;
            hold_q <= count_q;
          end
        end else begin
          mode_q  <= cw_rw;
          wptr_q  <= 1'b0;
          rptr_q  <= 1'b0;
          held_q  <= 1'b0;
          armed_q <= 1'b0;
          out_q   <= 1'b1;
        end
      end else if (wr_hit) begin
        if (mode_q == RW_PAIR && !wptr_q) begin
          stage_q <= wdata;
          wptr_q  <= 1'b1;
        end else if (load_now) begin
          reload_q <= new_val;
          count_q  <= new_val;
          armed_q  <= 1'b1;
          out_q    <= 1'b1;
          wptr_q   <= 1'b0;
        end
      end else if (armed_q && gate && tick) begin
        if (count_q == CW'(1)) begin
          count_q <= reload_q;
          out_q   <= 1'b1;
        end else begin
          count_q <= count_q - CW'(1);
          if (count_q == CW'(2)) out_q <= 1'b0;
        end
      end
    end
  end

  assign out = out_q;

  AST_CMD_HALTS: assert property (@(posedge clk) disable iff (rst)
    cw_hit && cw_rw != RW_LATCH |=> !armed_q && out_q); // R4

  AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (rst)
    !gate && !cw_hit && !wr_hit |=> $stable(count_q)); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    held_q && !cw_hit && !rd_hit |=> held_q && $stable(hold_q)); // R8

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    armed_q && gate && tick && !cw_hit && !wr_hit && count_q > CW'(2)
    |=> count_q == $past(count_q) - CW'(1)); // R9
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NUM_CH-1:0] ch_clk,
  input  logic [NUM_CH-1:0] ch_gate,
  input  logic              chain_01,
  output logic [NUM_CH-1:0] ch_out
);
  logic [DW-1:0] rd_bytes [NUM_CH];
  logic [DW-1:0] rd_sel;
  logic          ctrl_wr;
  logic [1:0]    cw_sel;
  rw_mode_e      cw_rw;

  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
  assign cw_sel  = wdata[DW-1:DW-2];
  assign cw_rw   = rw_mode_e'(wdata[DW-3:DW-4]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic src, tick;
    if (i == 1) begin : g_chain
      assign src = chain_01 ? ch_out[0] : ch_clk[i];
    end else begin : g_pin
      assign src = ch_clk[i];
    end

    pit_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (src),
      .rise (tick)
    );

    pit_channel #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .cw_hit  (ctrl_wr && cw_sel == 2'(i)),
      .cw_rw   (cw_rw),
      .wr_hit  (wr_en && addr == 2'(i)),
      .rd_hit  (rd_en && addr == 2'(i)),
      .wdata   (wdata),
      .tick    (tick),
      .gate    (ch_gate[i]),
      .rd_byte (rd_bytes[i]),
      .out     (ch_out[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == 2'(i)) rd_sel = rd_bytes[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= (addr == CTRL_ADDR) ? '0 : rd_sel;
  end

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == CTRL_ADDR |=> rdata == '0); // R2
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] ch_clk = '0;
  logic [2:0] ch_gate = 3'b111;
  logic       chain_01 = 1'b0;
  logic [2:0] ch_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  pit_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_clk(ch_clk), .ch_gate(ch_gate),
    .chain_01(chain_01), .ch_out(ch_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      report();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_pair(logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic pulse(int ch, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ch_clk[ch] = 1'b1;
      @(negedge clk); ch_clk[ch] = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 outputs high", int'(ch_out), 7);
    chk("R1 rdata zero", int'(rdata), 0);
    pulse(2, 4);
    chk("R1 idle channel output", int'(ch_out[2]), 1);
    wr(2'd3, 8'hAB);
    rd(2'd3, d);
    chk("R2 command read zero", int'(d), 0);
  endtask

  task automatic t_pair_and_latch();
    int v;
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h05);
    pulse(0, 6);
    chk("R6 half load no count", int'(ch_out[0]), 1);
    wr(2'd0, 8'h00);
    pulse(0, 3);
    wr(2'd3, 8'h00);
    pulse(0, 1);
    chk("R9 fall at tick N-1", int'(ch_out[0]), 0);
    rd_pair(2'd0, v);
    chk("R8 held snapshot", v, 2);
    wr(2'd3, 8'h00);
    pulse(0, 1);
    chk("R9 rise on reload", int'(ch_out[0]), 1);
    wr(2'd3, 8'h00);
    pulse(0, 1);
    rd_pair(2'd0, v);
    chk("R8 second latch ignored", v, 1);
    rd_pair(2'd0, v);
    chk("R7 live paired read", v, 4);
    pulse(0, 3);
    chk("R9 periodic fall", int'(ch_out[0]), 0);
    wr(2'd3, 8'h34);
    chk("R4 command forces high", int'(ch_out[0]), 1);
    pulse(0, 3);
    wr(2'd3, 8'h00);
    rd_pair(2'd0, v);
    chk("R4 counting stopped", v, 1);
  endtask

  task automatic t_readback_quiet();
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h07);
    wr(2'd3, 8'hF4);
    wr(2'd0, 8'h00);
    pulse(0, 5);
    chk("R12 pointer kept", int'(ch_out[0]), 1);
    pulse(0, 1);
    chk("R12 reload value intact", int'(ch_out[0]), 0);
  endtask

  task automatic t_gate_binary();
    logic [7:0] d;
    wr(2'd3, 8'h91);
    wr(2'd2, 8'h10);
    ch_gate[2] = 1'b0;
    pulse(2, 5);
    rd(2'd2, d);
    chk("R10 gate low holds", int'(d), 16);
    chk("R10 gate low output", int'(ch_out[2]), 1);
    ch_gate[2] = 1'b1;
    pulse(2, 14);
    rd(2'd2, d);
    chk("R5 low byte read", int'(d), 2);
    chk("R3 binary not BCD", int'(ch_out[2]), 1);
    pulse(2, 1);
    chk("R3 binary fall at 15", int'(ch_out[2]), 0);
    rd(2'd2, d);
    chk("R5 low byte at one", int'(d), 1);
  endtask

  task automatic t_high_only();
    logic [7:0] d;
    wr(2'd3, 8'h64);
    wr(2'd1, 8'h01);
    rd(2'd1, d);
    chk("R5 high byte read", int'(d), 1);
    pulse(1, 1);
    rd(2'd1, d);
    chk("R5 high byte after tick", int'(d), 0);
  endtask

  task automatic t_cascade();
    chain_01 = 1'b1;
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h00);
    pulse(1, 6);
    chk("R11 own pin ignored", int'(ch_out[1]), 1);
    pulse(0, 3);
    @(negedge clk);
    chk("R11 cascade not yet", int'(ch_out[1]), 1);
    pulse(0, 1);
    @(negedge clk);
    chk("R11 cascade fall", int'(ch_out[1]), 0);
    pulse(0, 2);
    @(negedge clk);
    chk("R11 cascade rise", int'(ch_out[1]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pair_and_latch();
    t_readback_quiet();
    t_gate_binary();
    t_high_only();
    t_cascade();
    done = 1'b1;
    report();
  end
endmodule